// File: doc/BRIEF.md
# Vectored Interrupt Select Unit

This unit carries out the vectored interrupt select step of a small 8-bit processor with a 16-bit program counter. A single strobe starts the step. The unit freezes a snapshot of every pending source and picks the highest-ranked one under a fixed priority. It turns that rank into an even table offset and writes the offset into the low byte of the program counter. It then reads the two-byte handler address stored at that table slot and loads it into the program counter.

The software trap ranks highest. The non-maskable source ranks just below it. It is held as a sticky flag that a rising edge on its line sets, and only an explicit clear command or system reset removes it. Fourteen ordinary request lines fill the lower ranks. Instruction decode, per-source enables and the stack push are handled elsewhere.

Top module: `vecint_select`

## Requirements
- R1: After reset, `pc_out` is 0x0000, `done` and `mem_rd` are low, and the non-maskable flag is clear.
- R2: The slot byte is 0xE0 plus twice the winning rank, so it is always even and lies between 0xE0 and 0xFE. A pending `trap_req` (rank 15) always gives 0xFE.
- R3: The non-maskable flag has rank 14 (0xFC). `irq_req[k]` has rank k (0xE0+2k), so `irq_req[13]` gives 0xFA when the two higher sources are idle. The highest pending rank wins.
- R4: With nothing pending, the slot is 0xE0.
- R5: Sources are sampled on the clock edge that accepts `sel_start`. Changes to any source after that edge do not change the slot.
- R6: One edge after acceptance, `pc_out` holds {high byte of `pc_in` at acceptance, slot}. The high byte is unchanged.
- R7: The handler high byte is read from address {hi, slot} and the low byte from {hi, slot+1}, over a read port with one cycle of latency. Four edges after acceptance, `pc_out` equals {byte at slot, byte at slot+1}.
- R8: `done` is high for exactly one cycle, in the cycle in which `pc_out` first holds the handler address. A `sel_start` that arrives while a step is in progress is ignored, and no further step follows it.
- R9: The non-maskable flag is set only by a rising edge of `nmi_in`, whichever level the line then keeps. The flag stays set across select steps, and a one-cycle `nmi_clr` clears it. A rise and a clear on the same edge leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_start | input | 1 | Start strobe for one select step |
| trap_req | input | 1 | Software trap pending (rank 15) |
| nmi_in | input | 1 | Non-maskable request line, edge-detected |
| nmi_clr | input | 1 | Clears the non-maskable pending flag |
| irq_req | input | 14 | Ordinary pending lines, bit k has rank k |
| pc_in | input | 16 | Current program counter |
| mem_rd | output | 1 | Program-memory read request |
| mem_addr | output | 16 | Program-memory read address |
| mem_rdata | input | 8 | Read data, valid one cycle after the request |
| pc_out | output | 16 | New program counter |
| done | output | 1 | One-cycle strobe: handler address is loaded |

## Verification
Timing is counted from the edge that accepts the strobe. The slot appears on `pc_out` one edge later, together with the high-byte read request. The low-byte request follows one edge after that. `done` and the handler address appear four edges after acceptance. The bench drives and samples on falling edges and steps a fixed number of rising edges before each comparison. It can therefore tell when a result arrives one cycle early or one cycle late. Sources are changed right after the accepting edge, and a second strobe is held during the busy cycles, to show that neither has any effect.

// File: rtl/vis_pkg.sv
package vis_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SAMPLE  = 3'd1,
    ST_READ_HI = 3'd2,
    ST_READ_LO = 3'd3,
    ST_LOAD    = 3'd4
  } vis_state_e;
endpackage

// File: rtl/vis_rank_enc.sv
module vis_rank_enc #(
  parameter int NLVL   = 16,
  parameter int RANK_W = $clog2(NLVL)
) (
  input  logic [NLVL-1:0]   req,
  output logic [RANK_W-1:0] rank
);
  // Later (higher) indices overwrite earlier ones: highest set bit wins.
  always_comb begin
    rank = '0;
    for (int i = 0; i < NLVL; i++) begin
      if (req[i]) rank = RANK_W'(i);
    end
  end
endmodule

// File: rtl/vis_nmi_latch.sv
module vis_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic clr,
  output logic flag
);
  logic prev_q, flag_q, flag_d, rise;

  assign rise = line_in & ~prev_q;

  always_comb begin
    flag_d = flag_q;
    if (clr)  flag_d = 1'b0;
    if (rise) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= line_in;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

  // R9
  nmi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(line_in && !prev_q)) |=> !flag);
  // R9
  nmi_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_in && !prev_q) |=> flag);
endmodule

// File: rtl/vecint_select.sv
module vecint_select #(
  parameter int NLVL   = 16,
  parameter int BYTE_W = 8,
  parameter int PC_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_start,
  input  logic              trap_req,
  input  logic              nmi_in,
  input  logic              nmi_clr,
  input  logic [NLVL-3:0]   irq_req,
  input  logic [PC_W-1:0]   pc_in,
  output logic              mem_rd,
  output logic [PC_W-1:0]   mem_addr,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [PC_W-1:0]   pc_out,
  output logic              done
);
  import vis_pkg::*;

  localparam int RANK_W = $clog2(NLVL);
  localparam int PAD_W  = BYTE_W - RANK_W - 1;
  localparam int HI_W   = PC_W - BYTE_W;

  vis_state_e        state_q, state_d;
  logic [NLVL-1:0]   snap_q, snap_d, live_req;
  logic [HI_W-1:0]   pchi_q, pchi_d;
  logic [PC_W-1:0]   pc_q, pc_d;
  logic [BYTE_W-1:0] hbyte_q, hbyte_d;
  logic              done_q, done_d;
  logic              nmi_flag;
  logic [RANK_W-1:0] win_rank;
  logic [BYTE_W-1:0] slot;

  vis_nmi_latch u_nmi (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_in (nmi_in),
    .clr     (nmi_clr),
    .flag    (nmi_flag)
  );

  assign live_req = {trap_req, nmi_flag, irq_req};

  vis_rank_enc #(.NLVL(NLVL), .RANK_W(RANK_W)) u_enc (
    .req  (snap_q),
    .rank (win_rank)
  );

  assign slot = {{PAD_W{1'b1}}, win_rank, 1'b0};

  // next-state and datapath
  always_comb begin
    state_d = state_q;
    snap_d  = snap_q;
    pchi_d  = pchi_q;
    pc_d    = pc_q;
    hbyte_d = hbyte_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (sel_start) begin
        snap_d  = live_req;
        pchi_d  = pc_in[PC_W-1:BYTE_W];
        state_d = ST_SAMPLE;
      end
      ST_SAMPLE: begin
        pc_d    = {pchi_q, slot};
        state_d = ST_READ_HI;
      end
      ST_READ_HI: state_d = ST_READ_LO;
      ST_READ_LO: begin
        hbyte_d = mem_rdata;
        state_d = ST_LOAD;
      end
      ST_LOAD: begin
        pc_d    = PC_W'({hbyte_q, mem_rdata});
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      snap_q  <= '0;
      pchi_q  <= '0;
      pc_q    <= '0;
      hbyte_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      snap_q  <= snap_d;
      pchi_q  <= pchi_d;
      pc_q    <= pc_d;
      hbyte_q <= hbyte_d;
      done_q  <= done_d;
    end
  end

  assign mem_rd   = (state_q == ST_READ_HI) || (state_q == ST_READ_LO);
  assign mem_addr = (state_q == ST_READ_LO) ? {pc_q[PC_W-1:1], 1'b1} : pc_q;
  assign pc_out   = pc_q;
  assign done     = done_q;

  // R2
  slot_even_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SAMPLE) |=> (pc_q[0] == 1'b0) && (pc_q[BYTE_W-1 -: PAD_W] == {PAD_W{1'b1}}));
  // R6
  pc_high_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SAMPLE) |=> (pc_q[PC_W-1:BYTE_W] == $past(pchi_q)));
  // R7
  lo_addr_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READ_HI) |=> (mem_rd && mem_addr == $past(mem_addr) + PC_W'(1)));
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R8
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && sel_start) |=> (state_q != ST_SAMPLE));
endmodule

// File: tb/vecint_select_tb.sv
`timescale 1ns/1ps
module vecint_select_tb;
  logic        clk, rst_n, sel_start, trap_req, nmi_in, nmi_clr;
  logic [13:0] irq_req;
  logic [15:0] pc_in, mem_addr, pc_out;
  logic        mem_rd, done;
  logic [7:0]  mem_rdata;
  int checks = 0, fails = 0;
  bit fin = 0;

  vecint_select u_dut (
    .clk(clk), .rst_n(rst_n), .sel_start(sel_start), .trap_req(trap_req),
    .nmi_in(nmi_in), .nmi_clr(nmi_clr), .irq_req(irq_req), .pc_in(pc_in),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .pc_out(pc_out), .done(done)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] fmem(input logic [15:0] a);
    return a[15:8] ^ {a[6:0], a[7]} ^ 8'h5A;
  endfunction

  // program memory model, one cycle read latency
  always @(posedge clk) if (mem_rd) mem_rdata <= fmem(mem_addr);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one select step; checks slot, fetch addresses, handler and done timing
  task automatic run_select(input string tag, input logic [13:0] irq, input logic trap,
                            input logic [15:0] pc, input logic [7:0] exp_slot,
                            input bit disturb, input bit busy_start);
    logic [15:0] sa = {pc[15:8], exp_slot};
    @(negedge clk);
    irq_req = irq; trap_req = trap; pc_in = pc; sel_start = 1;
    @(posedge clk);                  // accepting edge
    @(negedge clk);
    sel_start = 0;
    if (disturb) begin irq_req = ~irq; trap_req = ~trap; pc_in = ~pc; end
    @(posedge clk);                  // +1: slot in pc
    @(negedge clk);
    chk({tag, " slot pc (R6)"}, pc_out, sa);
    chk("R7 hi read request", {15'd0, mem_rd}, 16'd1);
    chk("R7 hi read addr", mem_addr, sa);
    if (busy_start) begin sel_start = 1; trap_req = 1; end
    @(posedge clk);                  // +2
    @(negedge clk);
    chk("R7 lo read addr", mem_addr, sa | 16'd1);
    chk("R8 no early done", {15'd0, done}, 16'd0);
    @(posedge clk);                  // +3
    @(negedge clk);
    sel_start = 0;
    @(posedge clk);                  // +4
    @(negedge clk);
    chk("R8 done high", {15'd0, done}, 16'd1);
    chk({tag, " handler (R7)"}, pc_out, {fmem(sa), fmem(sa | 16'd1)});
    @(posedge clk);
    @(negedge clk);
    chk("R8 done one cycle", {15'd0, done}, 16'd0);
    if (busy_start) begin
      repeat (3) begin
        @(posedge clk); @(negedge clk);
        chk("R8 busy start ignored: no read", {15'd0, mem_rd}, 16'd0);
        chk("R8 busy start ignored: pc held", pc_out, {fmem(sa), fmem(sa | 16'd1)});
      end
    end
    irq_req = '0; trap_req = 0; pc_in = '0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); nmi_clr = 1;
    @(negedge clk); nmi_clr = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 pc_out", pc_out, 16'h0000);
    chk("R1 done", {15'd0, done}, 16'd0);
    chk("R1 mem_rd", {15'd0, mem_rd}, 16'd0);
    run_select("R1 R4 nmi flag clear, nothing pending", 14'h0, 0, 16'h1234, 8'hE0, 0, 0);
  endtask

  task automatic t_priority();
    run_select("R2 trap over all", 14'h3FFF, 1, 16'hA5F0, 8'hFE, 0, 0);
    run_select("R3 ext line rank 13", 14'h2013, 0, 16'h4400, 8'hFA, 0, 0);
    run_select("R3 single line 5", 14'h0020, 0, 16'hC3C3, 8'hEA, 0, 0);
    run_select("R3 lines 0 and 3", 14'h0009, 0, 16'h0101, 8'hE6, 0, 0);
    run_select("R4 only line 0", 14'h0001, 0, 16'hFFFF, 8'hE0, 0, 0);
  endtask

  task automatic t_sampling();
    run_select("R5 late changes ignored", 14'h0004, 0, 16'h7E12, 8'hE4, 1, 0);
  endtask

  task automatic t_nmi();
    @(negedge clk); nmi_in = 1;
    run_select("R9 R3 nmi over ext", 14'h2000, 0, 16'h3300, 8'hFC, 0, 0);
    run_select("R9 nmi flag held", 14'h0000, 0, 16'h3300, 8'hFC, 0, 0);
    pulse_clr();
    run_select("R9 cleared, level high does not reset", 14'h0000, 0, 16'h3300, 8'hE0, 0, 0);
    @(negedge clk); nmi_in = 0;
    @(negedge clk); nmi_in = 1;
    run_select("R9 new rise sets flag", 14'h0100, 0, 16'h9000, 8'hFC, 0, 0);
    run_select("R2 trap over nmi", 14'h0000, 1, 16'h9000, 8'hFE, 0, 0);
    @(negedge clk); nmi_in = 0; nmi_clr = 1;
    @(negedge clk); nmi_in = 1;           // rise together with clear
    @(negedge clk); nmi_clr = 0;
    run_select("R9 rise wins over clear", 14'h0000, 0, 16'h5500, 8'hFC, 0, 0);
    pulse_clr();
    nmi_in = 0;
  endtask

  task automatic t_busy();
    run_select("R8 start during busy", 14'h0002, 0, 16'h6060, 8'hE2, 0, 1);
  endtask

  initial begin
    rst_n = 0; sel_start = 0; trap_req = 0; nmi_in = 0; nmi_clr = 0;
    irq_req = '0; pc_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_priority();
    t_sampling();
    t_nmi();
    t_busy();
    fin = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule